// File: doc/BRIEF.md
# Latched Cycle-Count Interrupt Timer

This block counts CPU bus cycles and raises an interrupt line once a programmed number of cycles has gone by. Software loads a 16-bit reload value one byte at a time into a holding latch. The live counter does not change while the latch is written. A write to a separate control register then does three things at once: it acknowledges any pending interrupt, transfers the latch into the live counter, and arms or disarms counting.

The block watches the CPU write bus directly. A register is selected by the top address bit together with the low address nibble, so each register appears at many mirror addresses. Counting advances only on a one-per-CPU-cycle enable pulse. The interrupt output is level-sensitive and stays high until software writes the control register again.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the interrupt output is low, the latch and the live counter are zero, and counting is disarmed.
- R2: A register write takes effect only when `bus_we` is high and address bit 15 is 1. The low nibble picks the register and bits 14..4 are ignored. A write with bit 15 at 0, or with `bus_we` low, has no effect.
- R3: Nibble 0xB loads latch bits 7..0 and nibble 0xC loads latch bits 15..8. Neither write changes the live counter or the interrupt output.
- R4: A write to nibble 0xA copies the latch into the live counter and clears the interrupt. Data bit 0 becomes the count-enable, where 1 arms counting.
- R5: While counting is armed, the counter drops by one on each cycle where `cyc_tick` is high. On cycles without `cyc_tick` it holds.
- R6: After the counter is loaded with N > 0 and armed, the interrupt goes high on the clock edge of the N-th `cyc_tick` pulse, and not before.
- R7: A control write that arms counting while the latch holds zero raises the interrupt on the edge of that same write.
- R8: Once high, the interrupt stays high until the next control write. The counter stops at zero and does not wrap.
- R9: When a control write and a `cyc_tick` pulse fall in the same cycle, the load wins and no decrement happens in that cycle.
- R10: A control write with data bit 0 at 0 disarms counting, and the interrupt then stays low whatever `cyc_tick` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | CPU write strobe, one cycle per write |
| cyc_tick | input | 1 | One-per-CPU-cycle count enable |
| irq_o | output | 1 | Level-sensitive interrupt, active high |

## Verification
Every result comes from a single register stage, so the interrupt level caused by a write or a tick appears right after the clock edge that samples that stimulus. The one exception is reset release, which first passes through a two-stage synchronizer.

For each stimulus cycle, the driver queues the interrupt level that the requirements predict just after the next edge. The monitor pops that entry one nanosecond after the edge and compares it with the output. Tick counts such as N and 256 are driven one pulse per queued entry, so the first cycle with a high interrupt is pinned exactly.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  typedef logic [3:0] reg_ofs_t;

  localparam reg_ofs_t OFS_CTRL   = 4'hA;
  localparam reg_ofs_t OFS_LATCH0 = 4'hB;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              ctrl_stb,
  output logic [NBYTES-1:0] byte_stb
);
  logic sel;
  logic unused_addr_bits;

  assign sel              = we & addr[ADDR_W-1];
  assign unused_addr_bits = ^addr[ADDR_W-2:4];
  assign ctrl_stb         = sel & (addr[3:0] == OFS_CTRL);

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    localparam reg_ofs_t OFS_K = reg_ofs_t'(OFS_LATCH0 + k);
    assign byte_stb[k] = sel & (addr[3:0] == OFS_K);
  end

  // R2: at most one register is selected by a single write
  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_stb, byte_stb}));
endmodule

// File: rtl/cyc_irq_latch.sv
module cyc_irq_latch #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W/DATA_W-1:0] byte_stb,
  output logic [CNT_W-1:0]  latch_q
);
  localparam int NBYTES = CNT_W / DATA_W;

  logic [CNT_W-1:0] latch_d;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_comb begin
      latch_d[k*DATA_W +: DATA_W] = latch_q[k*DATA_W +: DATA_W];
      if (byte_stb[k]) latch_d[k*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // R3: the latch only moves on a byte write
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb == '0) |=> $stable(latch_q));
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_stb,
  input  logic             en_bit,
  input  logic [CNT_W-1:0] latch_q,
  input  logic             cyc_tick,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    irq_d = irq_q;
    if (ctrl_stb) begin
      cnt_d = latch_q;
      run_d = en_bit;
      irq_d = en_bit && (latch_q == '0);
    end else if (run_q && cyc_tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) irq_d = 1'b1;
      end else begin
        irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assert_load_on_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb |=> (cnt_q == $past(latch_q)));
  assert_ack_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && !en_bit) |=> !irq_q);
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_stb && !(run_q && cyc_tick)) |=> $stable(cnt_q));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_stb && run_q && cyc_tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ctrl_stb) |=> irq_q);
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_stb) |=> (cnt_q == '0));
  assert_arm_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && en_bit && latch_q == '0) |=> irq_q);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              cyc_tick,
  output logic              irq_o
);
  localparam int NBYTES = CNT_W / DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              ctrl_stb;
  logic [NBYTES-1:0] byte_stb;
  logic [CNT_W-1:0]  latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cyc_irq_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) decode_i (
    .clk(clk), .rst_n(rst_core_n), .addr(bus_addr), .we(bus_we),
    .ctrl_stb(ctrl_stb), .byte_stb(byte_stb)
  );

  cyc_irq_latch #(.CNT_W(CNT_W), .DATA_W(DATA_W)) latch_i (
    .clk(clk), .rst_n(rst_core_n), .wdata(bus_wdata),
    .byte_stb(byte_stb), .latch_q(latch_q)
  );

  cyc_irq_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst_n(rst_core_n), .ctrl_stb(ctrl_stb), .en_bit(bus_wdata[0]),
    .latch_q(latch_q), .cyc_tick(cyc_tick), .irq_q(irq_o)
  );

  // R1: the interrupt is low while the core is held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_core_n |-> !irq_o);
endmodule

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;
  typedef struct { bit exp; string req; } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        cyc_tick = 1'b0;
  logic        irq_o;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  cyc_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .cyc_tick(cyc_tick), .irq_o(irq_o)
  );

  // monitor: compare one queued item just after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (irq_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_o=%0b expected %0b", it.req, irq_o, it.exp);
      end
    end
  end

  task automatic drive(input bit we, input logic [15:0] a, input logic [7:0] d,
                       input bit tick, input bit exp, input string req);
    item_t it;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; cyc_tick = tick;
    it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit exp, input string req);
    drive(1'b1, a, d, 1'b0, exp, req);
  endtask

  task automatic tk(input bit tick, input bit exp, input string req);
    drive(1'b0, 16'h0000, 8'h00, tick, exp, req);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tk(1'b1, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tk(1'b1, 1'b0, "R1");
    // R7: arm with latch at reset value zero
    wr(16'h800A, 8'h01, 1'b1, "R7");
    tk(1'b0, 1'b1, "R8");
    tk(1'b1, 1'b1, "R8");
    // R2: ignored writes
    wr(16'h000A, 8'h00, 1'b1, "R2");
    drive(1'b0, 16'h800A, 8'h00, 1'b0, 1'b1, "R2");
    // R3: latch writes leave irq alone
    wr(16'h800B, 8'h03, 1'b1, "R3");
    wr(16'h800C, 8'h00, 1'b1, "R3");
    // R4 / R6
    wr(16'h800A, 8'h01, 1'b0, "R4");
    tk(1'b1, 1'b0, "R6");
    tk(1'b1, 1'b0, "R6");
    tk(1'b1, 1'b1, "R6");
    for (int i = 0; i < 3; i++) tk(1'b1, 1'b1, "R8");
    // R5: hold without ticks
    wr(16'h800B, 8'h02, 1'b1, "R3");
    wr(16'h800A, 8'h01, 1'b0, "R4");
    for (int i = 0; i < 5; i++) tk(1'b0, 1'b0, "R5");
    tk(1'b1, 1'b0, "R5");
    tk(1'b1, 1'b1, "R5");
    // R3: latch write does not touch the live counter
    wr(16'h800A, 8'h01, 1'b0, "R4");
    wr(16'h800B, 8'h50, 1'b0, "R3");
    tk(1'b1, 1'b0, "R3");
    tk(1'b1, 1'b1, "R3");
    // R10: disarm
    wr(16'h800B, 8'h01, 1'b1, "R3");
    wr(16'h800A, 8'h00, 1'b0, "R10");
    for (int i = 0; i < 4; i++) tk(1'b1, 1'b0, "R10");
    // R2: mirror addresses
    wr(16'hA5FB, 8'h02, 1'b0, "R2");
    wr(16'hFF3A, 8'h01, 1'b0, "R2");
    tk(1'b1, 1'b0, "R2");
    tk(1'b1, 1'b1, "R2");
    // R9: load wins over a coincident tick
    wr(16'h800B, 8'h02, 1'b1, "R3");
    drive(1'b1, 16'h800A, 8'h01, 1'b1, 1'b0, "R9");
    tk(1'b1, 1'b0, "R9");
    tk(1'b1, 1'b1, "R9");
    // R3/R6: high byte, count of 256
    wr(16'h800B, 8'h00, 1'b1, "R3");
    wr(16'h800C, 8'h01, 1'b1, "R3");
    wr(16'h800A, 8'h01, 1'b0, "R4");
    for (int i = 0; i < 255; i++) tk(1'b1, 1'b0, "R6");
    tk(1'b1, 1'b1, "R6");
    tk(1'b0, 1'b1, "R8");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_fail++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule